// File: doc/BRIEF.md
# Parallel-to-Serial Channel Multiplexer

This block moves the state of four internal 16-channel groups across one synchronous serial link. The groups are two timer channel banks, a PWM/double-action bank and a general-purpose bank. When a frame is launched, the block takes a snapshot of all sixty-four source bits. It shifts out as many of them as the configured stream length calls for. During the same bit slots it shifts an equal number of bits back in from the external device. When the frame ends, the block copies the received bits to the four destination groups in one step.

The serial clock is the system clock divided by a configurable ratio. A frame is marked either by an active-low enable held for the whole frame (SPI-style) or by a sync pulse spanning the first bit (TDM-style). Frames either repeat while the block is enabled (continuous) or run once per start request (start-transmit-receive). A start-transmit-receive frame reports completion through a sticky done level and a one-cycle interrupt pulse. Any group can be switched to an internal short. Its destination then takes the group's own snapshot instead of the received bits, with no traffic needed on the external link.

Top module: `pinmux_serializer`

## Requirements
- R1: After a synchronous reset, ser_clk=0, ser_dout=0, ser_csn=1, ser_sync=0, busy=0, done=0, irq=0, and all destination groups are zero.
- R2: Bit slot k of a frame carries bit k%16 of group k/16. Groups are numbered timer_a=0, timer_b=1, pwm=2, gpio=3. The values used are the ones sampled on the clock edge that launches the frame. ser_dout is 0 whenever busy is low.
- R3: Each bit slot lasts 2*(cfg_div+1) system clocks. ser_clk is low for the first half of the slot and high for the second half, and it stays low while idle. busy rises one clock after the launching edge.
- R4: ser_din is sampled on the edge where ser_clk rises, into receive slot k of the current bit.
- R5: Destination outputs change only on the edge that ends a frame. Slots at or above the stream length keep their previous values.
- R6: When cfg_short[g] is set at launch, destination group g takes that group's launch snapshot instead of the received bits.
- R7: A stream length of 0 runs a 1-bit frame. A length above 64 runs a 64-bit frame.
- R8: With cfg_tdm=0, ser_csn is low exactly while busy, and ser_sync stays 0.
- R9: With cfg_tdm=1, ser_csn stays 1, and ser_sync is high exactly during bit slot 0 of a frame.
- R10: With cfg_enable=1 and cfg_cont=1, a new frame launches on the first idle clock after the previous frame ends, and continuous frames never raise done or irq.
- R11: With cfg_cont=0, a start pulse while idle launches one frame. At its end, done is set and irq pulses for one clock. done clears at the next launch, and start is ignored while busy.
- R12: With cfg_enable=0, no frame launches, whether from start or from cfg_cont.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Allows frames to launch |
| cfg_tdm | input | 1 | 1 = sync-pulse framing, 0 = active-low enable framing |
| cfg_cont | input | 1 | 1 = continuous frames, 0 = one frame per start |
| cfg_len | input | 7 | Stream length in bits, clamped to 1..64 |
| cfg_div | input | 8 | Clock ratio; a bit slot lasts 2*(cfg_div+1) clocks |
| cfg_short | input | 4 | Per-group internal short select |
| start | input | 1 | Start request for a single frame |
| src_timer_a | input | 16 | Source group 0 |
| src_timer_b | input | 16 | Source group 1 |
| src_pwm | input | 16 | Source group 2 |
| src_gpio | input | 16 | Source group 3 |
| ser_din | input | 1 | Serial data from the external device |
| dst_timer_a | output | 16 | Destination group 0 |
| dst_timer_b | output | 16 | Destination group 1 |
| dst_pwm | output | 16 | Destination group 2 |
| dst_gpio | output | 16 | Destination group 3 |
| ser_clk | output | 1 | Serial clock |
| ser_dout | output | 1 | Serial data to the external device |
| ser_csn | output | 1 | Active-low frame enable (SPI-style) |
| ser_sync | output | 1 | Frame sync pulse (TDM-style) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Sticky end-of-frame flag for single frames |
| irq | output | 1 | One-clock end-of-frame pulse for single frames |

## Verification
A full 64-bit frame with the data output looped back to the data input must reproduce every source group at the destinations. This pattern separates a correct slot order and sample point from an off-by-one or a swapped group. Short frames with pseudo-random return data, in both framing styles, show that only the lower slots are written and the rest are held. A frame with alternate groups shorted tells the snapshot path from the receive path. Lengths of 0 and 100 are timed against the expected frame duration, and a continuous run with the sources changing between frames shows that each frame uses its own launch snapshot.

// File: rtl/psm_pkg.sv
package psm_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;

  typedef struct packed {
    logic tdm;
    logic cont;
  } mode_t;
endpackage

// File: rtl/psm_clkdiv.sv
module psm_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)    cnt_q <= '0;
    else if (cnt_q == div) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == div);
endmodule

// File: rtl/psm_frame_ctrl.sv
module psm_frame_ctrl
  import psm_pkg::*;
#(
  parameter int TOTAL = 64,
  parameter int DIV_W = 8,
  parameter int LEN_W = $clog2(TOTAL + 1),
  parameter int IDX_W = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_enable,
  input  logic             cfg_tdm,
  input  logic             cfg_cont,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             start,
  input  logic             tick,
  output logic             busy,
  output logic [DIV_W-1:0] div_l,
  output logic [LEN_W-1:0] len_l,
  output logic [IDX_W-1:0] bit_idx,
  output logic             tdm_l,
  output logic             launch,
  output logic             sample,
  output logic             finish,
  output logic             sclk,
  output logic             done,
  output logic             irq
);
  phase_e phase_q;
  mode_t  mode_q;
  logic   last_bit;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v);
    if (v == '0)                return LEN_W'(1);
    else if (v > LEN_W'(TOTAL)) return LEN_W'(TOTAL);
    else                        return v;
  endfunction

  assign launch   = !busy && cfg_enable && (cfg_cont || start);
  assign last_bit = (LEN_W'(bit_idx) == (len_l - 1'b1));
  assign sample   = busy && tick && (phase_q == PH_LOW);
  assign finish   = busy && tick && (phase_q == PH_HIGH) && last_bit;
  assign tdm_l    = mode_q.tdm;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      phase_q <= PH_LOW;
      bit_idx <= '0;
      len_l   <= LEN_W'(1);
      div_l   <= '0;
      mode_q  <= '0;
      sclk    <= 1'b0;
      done    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (launch) begin
        busy    <= 1'b1;
        phase_q <= PH_LOW;
        bit_idx <= '0;
        len_l   <= clamp_len(cfg_len);
        div_l   <= cfg_div;
        mode_q  <= '{tdm: cfg_tdm, cont: cfg_cont};
        done    <= 1'b0;
      end else if (busy && tick) begin
        if (phase_q == PH_LOW) begin
          phase_q <= PH_HIGH;
          sclk    <= 1'b1;
        end else begin
          phase_q <= PH_LOW;
          sclk    <= 1'b0;
          if (last_bit) begin
            busy <= 1'b0;
            if (!mode_q.cont) begin
              done <= 1'b1;
              irq  <= 1'b1;
            end
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/psm_lanes.sv
module psm_lanes #(
  parameter int GRP_W = 16,
  parameter int N_GRP = 4,
  parameter int TOTAL = GRP_W * N_GRP,
  parameter int LEN_W = $clog2(TOTAL + 1),
  parameter int IDX_W = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             sample,
  input  logic             finish,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic [LEN_W-1:0] len_l,
  input  logic [N_GRP-1:0] short_cfg,
  input  logic [TOTAL-1:0] src_flat,
  input  logic             ser_din,
  output logic             dout_bit,
  output logic [TOTAL-1:0] dst_flat
);
  logic [TOTAL-1:0] snap_q;
  logic [TOTAL-1:0] shadow_q;
  logic [N_GRP-1:0] short_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q  <= '0;
      short_q <= '0;
    end else if (launch) begin
      snap_q  <= src_flat;
      short_q <= short_cfg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         shadow_q <= '0;
    else if (sample) shadow_q[bit_idx] <= ser_din;
  end

  assign dout_bit = snap_q[bit_idx];

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic [GRP_W-1:0] grp_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        grp_q <= '0;
      end else if (finish) begin
        for (int i = 0; i < GRP_W; i++) begin
          if (LEN_W'(g * GRP_W + i) < len_l)
            grp_q[i] <= short_q[g] ? snap_q[g*GRP_W+i] : shadow_q[g*GRP_W+i];
        end
      end
    end
    assign dst_flat[g*GRP_W +: GRP_W] = grp_q;
  end
endmodule

// File: rtl/pinmux_serializer.sv
module pinmux_serializer #(
  parameter int GRP_W = 16,
  parameter int DIV_W = 8,
  localparam int N_GRP = 4,
  localparam int TOTAL = GRP_W * N_GRP,
  localparam int LEN_W = $clog2(TOTAL + 1),
  localparam int IDX_W = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_enable,
  input  logic             cfg_tdm,
  input  logic             cfg_cont,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [N_GRP-1:0] cfg_short,
  input  logic             start,
  input  logic [GRP_W-1:0] src_timer_a,
  input  logic [GRP_W-1:0] src_timer_b,
  input  logic [GRP_W-1:0] src_pwm,
  input  logic [GRP_W-1:0] src_gpio,
  input  logic             ser_din,
  output logic [GRP_W-1:0] dst_timer_a,
  output logic [GRP_W-1:0] dst_timer_b,
  output logic [GRP_W-1:0] dst_pwm,
  output logic [GRP_W-1:0] dst_gpio,
  output logic             ser_clk,
  output logic             ser_dout,
  output logic             ser_csn,
  output logic             ser_sync,
  output logic             busy,
  output logic             done,
  output logic             irq
);
  logic             tick, launch, sample, finish, tdm_l, dout_bit;
  logic [DIV_W-1:0] div_l;
  logic [LEN_W-1:0] len_l;
  logic [IDX_W-1:0] bit_idx;
  logic [TOTAL-1:0] src_flat, dst_flat;

  assign src_flat = {src_gpio, src_pwm, src_timer_b, src_timer_a};

  psm_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(busy), .div(div_l), .tick(tick)
  );

  psm_frame_ctrl #(.TOTAL(TOTAL), .DIV_W(DIV_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_tdm(cfg_tdm),
    .cfg_cont(cfg_cont), .cfg_len(cfg_len), .cfg_div(cfg_div), .start(start),
    .tick(tick), .busy(busy), .div_l(div_l), .len_l(len_l), .bit_idx(bit_idx),
    .tdm_l(tdm_l), .launch(launch), .sample(sample), .finish(finish),
    .sclk(ser_clk), .done(done), .irq(irq)
  );

  psm_lanes #(.GRP_W(GRP_W), .N_GRP(N_GRP), .TOTAL(TOTAL), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_lanes (
    .clk(clk), .rst(rst), .launch(launch), .sample(sample), .finish(finish),
    .bit_idx(bit_idx), .len_l(len_l), .short_cfg(cfg_short), .src_flat(src_flat),
    .ser_din(ser_din), .dout_bit(dout_bit), .dst_flat(dst_flat)
  );

  assign ser_dout    = busy && dout_bit;
  assign ser_csn     = !(busy && !tdm_l);
  assign ser_sync    = busy && tdm_l && (bit_idx == '0);
  assign dst_timer_a = dst_flat[0*GRP_W +: GRP_W];
  assign dst_timer_b = dst_flat[1*GRP_W +: GRP_W];
  assign dst_pwm     = dst_flat[2*GRP_W +: GRP_W];
  assign dst_gpio    = dst_flat[3*GRP_W +: GRP_W];
endmodule

// File: rtl/psm_checker.sv
module psm_checker #(
  parameter int TOTAL = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             ser_clk,
  input logic             ser_csn,
  input logic             ser_sync,
  input logic             done,
  input logic             irq,
  input logic [TOTAL-1:0] dst
);
  p_idle_clk_low_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ser_clk);

  p_dst_hold_in_frame_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> $stable(dst));

  p_csn_only_in_frame_r8: assert property (@(posedge clk) disable iff (rst)
    !ser_csn |-> busy);

  p_sync_framing_r9: assert property (@(posedge clk) disable iff (rst)
    ser_sync |-> (busy && ser_csn));

  p_irq_single_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_irq_with_done_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> (done && !busy));
endmodule

bind pinmux_serializer psm_checker #(.TOTAL(TOTAL)) u_psm_chk (
  .clk(clk), .rst(rst), .busy(busy), .ser_clk(ser_clk), .ser_csn(ser_csn),
  .ser_sync(ser_sync), .done(done), .irq(irq),
  .dst({dst_gpio, dst_pwm, dst_timer_b, dst_timer_a})
);

// File: tb/tb_pinmux_serializer.sv
module tb_pinmux_serializer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_enable = 0, cfg_tdm = 0, cfg_cont = 0, start = 0;
  logic [6:0] cfg_len = 7'd64;
  logic [7:0] cfg_div = 8'd0;
  logic [3:0] cfg_short = 4'd0;
  logic [15:0] src_timer_a = 0, src_timer_b = 0, src_pwm = 0, src_gpio = 0;
  logic [15:0] dst_timer_a, dst_timer_b, dst_pwm, dst_gpio;
  logic ser_clk, ser_dout, ser_csn, ser_sync, busy, done, irq, ser_din;
  logic loop_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  assign ser_din = loop_mode ? ser_dout : lfsr[0];
  always @(negedge clk) lfsr <= {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};

  pinmux_serializer dut (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_tdm(cfg_tdm),
    .cfg_cont(cfg_cont), .cfg_len(cfg_len), .cfg_div(cfg_div), .cfg_short(cfg_short),
    .start(start), .src_timer_a(src_timer_a), .src_timer_b(src_timer_b),
    .src_pwm(src_pwm), .src_gpio(src_gpio), .ser_din(ser_din),
    .dst_timer_a(dst_timer_a), .dst_timer_b(dst_timer_b), .dst_pwm(dst_pwm),
    .dst_gpio(dst_gpio), .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_csn(ser_csn),
    .ser_sync(ser_sync), .busy(busy), .done(done), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  // Behavioural reference: time counted in clocks since launch.
  bit m_busy, m_sclk, m_done, m_irq, m_tdm, m_cont;
  int m_t, m_d, m_len;
  bit [3:0]  m_short;
  bit [63:0] m_snap, m_rx, m_dst;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_sclk = 0; m_done = 0; m_irq = 0; m_tdm = 0; m_cont = 0;
      m_t = 0; m_d = 1; m_len = 1; m_short = 0; m_snap = 0; m_rx = 0; m_dst = 0;
    end else begin
      m_irq = 0;
      if (!m_busy) begin
        if (cfg_enable && (cfg_cont || start)) begin
          m_busy = 1; m_t = 0; m_d = int'(cfg_div) + 1;
          m_len = (cfg_len == 0) ? 1 : ((cfg_len > 64) ? 64 : int'(cfg_len));
          m_tdm = cfg_tdm; m_cont = cfg_cont; m_short = cfg_short; m_done = 0;
          m_snap = {src_gpio, src_pwm, src_timer_b, src_timer_a};
        end
      end else begin
        int p, k;
        p = m_t % (2 * m_d);
        k = m_t / (2 * m_d);
        if (p == m_d - 1) begin m_rx[k] = ser_din; m_sclk = 1; end
        if (p == 2 * m_d - 1) begin
          m_sclk = 0;
          if (k == m_len - 1) begin
            m_busy = 0;
            for (int i = 0; i < m_len; i++)
              m_dst[i] = m_short[i / 16] ? m_snap[i] : m_rx[i];
            if (!m_cont) begin m_done = 1; m_irq = 1; end
          end
        end
        m_t++;
      end
    end
  end

  // Compare every clock, 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    cycles++;
    if (!rst) begin
      int k;
      bit e_dout;
      k = m_t / (2 * m_d);
      e_dout = m_busy ? m_snap[k] : 1'b0;
      chk(busy == m_busy, "R10 busy", 64'(busy), 64'(m_busy));
      chk(ser_clk == m_sclk, "R3 ser_clk", 64'(ser_clk), 64'(m_sclk));
      chk(ser_dout == e_dout, "R2 ser_dout", 64'(ser_dout), 64'(e_dout));
      chk(ser_csn == !(m_busy && !m_tdm), "R8 ser_csn", 64'(ser_csn), 64'(!(m_busy && !m_tdm)));
      chk(ser_sync == (m_busy && m_tdm && k == 0), "R9 ser_sync", 64'(ser_sync), 64'(m_busy && m_tdm && k == 0));
      chk(done == m_done && irq == m_irq, "R11 done/irq", {62'd0, done, irq}, {62'd0, m_done, m_irq});
      chk({dst_gpio, dst_pwm, dst_timer_b, dst_timer_a} == m_dst, "R5 destinations",
          {dst_gpio, dst_pwm, dst_timer_b, dst_timer_a}, m_dst);
    end
  end

  task automatic run_single(output int busy_cycles);
    busy_cycles = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (busy) begin
      busy_cycles++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk({ser_clk, ser_dout, ser_csn, ser_sync, busy, done, irq} == 7'b0010000, "R1 control pins",
        64'({ser_clk, ser_dout, ser_csn, ser_sync, busy, done, irq}), 64'(7'b0010000));
    chk({dst_gpio, dst_pwm, dst_timer_b, dst_timer_a} == 64'd0, "R1 destinations",
        {dst_gpio, dst_pwm, dst_timer_b, dst_timer_a}, 64'd0);

    // R12: start and continuous are ignored while disabled
    cfg_cont = 1; start = 1;
    repeat (10) begin @(negedge clk); chk(!busy, "R12 disabled launch", 64'(busy), 0); end
    cfg_cont = 0; start = 0;
    cfg_enable = 1;

    // R4/R2: full loopback frame, SPI framing, div 1
    src_timer_a = 16'h1234; src_timer_b = 16'hBEEF; src_pwm = 16'h0F0F; src_gpio = 16'hC3A5;
    loop_mode = 1; cfg_div = 8'd1; cfg_len = 7'd64;
    run_single(n);
    chk({dst_gpio, dst_pwm, dst_timer_b, dst_timer_a} == 64'hC3A5_0F0F_BEEF_1234, "R4 loopback",
        {dst_gpio, dst_pwm, dst_timer_b, dst_timer_a}, 64'hC3A5_0F0F_BEEF_1234);
    chk(n == 64 * 4, "R3 frame duration", 64'(n), 64'(256));
    chk(done, "R11 done set", 64'(done), 1);

    // R5: short TDM frame with random return bits, upper slots held
    loop_mode = 0; cfg_tdm = 1; cfg_div = 8'd0; cfg_len = 7'd20;
    run_single(n);
    chk(dst_gpio == 16'hC3A5 && dst_pwm == 16'h0F0F, "R5 upper slots held",
        {32'd0, dst_gpio, dst_pwm}, {32'd0, 16'hC3A5, 16'h0F0F});

    // R7: length 0 and 100 are clamped
    cfg_len = 7'd0; cfg_div = 8'd2;
    run_single(n);
    chk(n == 6, "R7 length zero", 64'(n), 64'(6));
    cfg_len = 7'd100; cfg_div = 8'd0;
    run_single(n);
    chk(n == 128, "R7 length over range", 64'(n), 64'(128));

    // R6: groups 0 and 2 shorted to their own snapshots
    src_timer_a = 16'h5A5A; src_timer_b = 16'h1111; src_pwm = 16'h7E81; src_gpio = 16'h2222;
    cfg_short = 4'b0101; cfg_tdm = 0; cfg_len = 7'd64;
    run_single(n);
    chk(dst_timer_a == 16'h5A5A && dst_pwm == 16'h7E81, "R6 shorted groups",
        {32'd0, dst_pwm, dst_timer_a}, {32'd0, 16'h7E81, 16'h5A5A});
    cfg_short = 4'd0;

    // R11: start during a frame is ignored; done clears on launch
    cfg_len = 7'd8;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(!done, "R11 done cleared", 64'(done), 0);
    repeat (5) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(!busy, "R11 no extra frame", 64'(busy), 0);

    // R10: continuous TDM frames with changing sources, then stop
    cfg_tdm = 1; cfg_cont = 1; cfg_len = 7'd24; cfg_div = 8'd1; loop_mode = 1;
    for (int f = 0; f < 4; f++) begin
      repeat (60) @(negedge clk);
      src_timer_a = src_timer_a + 16'h0313;
      src_timer_b = ~src_timer_b;
    end
    cfg_cont = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(!busy && !done, "R10 stop after continuous", {62'd0, busy, done}, 0);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule